// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Port

This block is a write-only configuration port. It has three serial inputs: a data line, a clock and an enable strobe. While the strobe is high, the block shifts in one 16-bit frame. The frame carries a 4-bit register address followed by a 12-bit data word, and it is sent most significant bit first. A bit is taken on each falling edge of the serial clock. When the strobe falls, a frame of exactly 16 bits goes into a holding register for the addressed field. A frame of any other length is thrown away.

The fields that drive the rest of the chip do not change when a frame arrives. They change only on a load event, which comes from a separate frame-sync input. At a load event every field copies its holding value, and all fields update in the same system clock cycle. The active field itself selects the frame-sync edge that counts as a load: rising or falling.

Without a vertical sync, the frame-sync input can be tied to the strobe and the falling edge selected. A write then takes effect at the end of its own frame. All serial and sync inputs are synchronised into the system clock domain. The serial clock must therefore be much slower than the system clock.

Top module: `ser_cfg_port`

## Requirements
- R1: After reset, gain_code, dac_code, clamp_code and gain_ext are 0, and ctrl_word is 10'h204 (bits 2 and 9 set, all other bits clear).
- R2: A frame is the sequence of data-line values taken on the falling serial-clock edges while the strobe is high. The first bit is address bit 3, and the last bit is data bit 0. The frame is accepted when the strobe falls.
- R3: An accepted frame leaves every output unchanged until the next load event.
- R4: On a load, each field takes the last accepted value for its address. Address 0 drives gain_code from data[7:0]. Address 1 drives dac_code from data[7:0]. Address 2 drives clamp_code from data[6:0]. Address 3 drives ctrl_word from data[9:0]. Address 4 drives gain_ext from data[7]. Data bits above each field are ignored.
- R5: A strobe period with other than exactly 16 falling serial-clock edges is discarded. A later load does not show its data.
- R6: Frames to addresses 5 through 15 change no output, even after a load.
- R7: When ctrl_word[8] is 0, a rising edge of frame_sync is a load. When ctrl_word[8] is 1, a falling edge is a load. The other edge has no effect. All fields update in the same cycle.
- R8: If a frame is accepted in the same cycle as a load, that load already applies the frame. With frame_sync tied to the strobe and ctrl_word[8] = 1, a write therefore takes effect when its strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data, MSB first |
| ser_clk | input | 1 | Serial clock; bits are taken on its falling edge |
| ser_en | input | 1 | Frame strobe, active high |
| frame_sync | input | 1 | Sync input whose selected edge is a load |
| gain_code | output | 8 | Active gain code |
| dac_code | output | 8 | Active auxiliary DAC code |
| clamp_code | output | 7 | Active clamp level, 0 to 127 |
| ctrl_word | output | 10 | Active polarity and mode bits. Bit 0 is dummy-clamp polarity, bit 1 is black-clamp polarity, bit 3 is blanking polarity, bit 4 is sample-pulse polarity, bit 5 is pixel-clock edge, bit 6 is output-enable sense, bit 7 is standby sense, and bit 8 is load-edge select. Bits 2 and 9 must be written as 1. |
| gain_ext | output | 1 | Extended gain range select |

## Verification
Some properties are checked on every cycle. The frame-length counter never passes its saturation value. An accepted-frame strobe lasts a single cycle. The active fields hold steady in every cycle without a load. A frame to a test address never touches the holding registers.

Other behaviour shows only in the bench's scenarios:
- the bit order and the mapping of each field;
- that short and long frames are dropped;
- the edge selection after ctrl_word[8] changes;
- tied-strobe operation, where a write appears at the end of its own frame.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 12;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int GAIN_W  = 8;
  localparam int DAC_W   = 8;
  localparam int CLAMP_W = 7;
  localparam int CTRL_W  = 10;
  localparam int EDGE_BIT = 8;
  localparam int EXT_BIT  = 7;
  localparam logic [CTRL_W-1:0] CTRL_RST = 10'h204;
  localparam logic [ADDR_W-1:0] A_GAIN  = 4'd0;
  localparam logic [ADDR_W-1:0] A_DAC   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CLAMP = 4'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd3;
  localparam logic [ADDR_W-1:0] A_EXT   = 4'd4;
endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ser_cfg_shifter.sv
module ser_cfg_shifter #(
  parameter int FRAME_W = 16,
  localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sd,
  input  logic               sck,
  input  logic               sen,
  output logic               frm_vld,
  output logic [FRAME_W-1:0] frm
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(FRAME_W);

  logic             sck_q, sen_q;
  logic [CNT_W-1:0] cnt;
  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q   <= 1'b0;
      sen_q   <= 1'b0;
      cnt     <= CNT_MAX;
      sh      <= '0;
      frm     <= '0;
      frm_vld <= 1'b0;
    end else begin
      sck_q   <= sck;
      sen_q   <= sen;
      frm_vld <= 1'b0;
      if (sen && !sen_q) begin
        cnt <= '0;
      end else if (sen && sck_q && !sck) begin
        sh <= {sh[FRAME_W-2:0], sd};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (!sen && sen_q && cnt == CNT_OK) begin
        frm_vld <= 1'b1;
        frm     <= sh;
      end
    end
  end

  // R5
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);

  // R2
  frm_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frm_vld |=> !frm_vld);
endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank
  import ser_cfg_pkg::*;
#(
  parameter int FRAME_W = ser_cfg_pkg::FRAME_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_vld,
  input  logic [FRAME_W-1:0] frm,
  input  logic               fs,
  output logic [GAIN_W-1:0]  gain_act,
  output logic [DAC_W-1:0]   dac_act,
  output logic [CLAMP_W-1:0] clamp_act,
  output logic [CTRL_W-1:0]  ctrl_act,
  output logic               ext_act
);
  localparam int DW = FRAME_W - ADDR_W;

  logic [ADDR_W-1:0]  f_addr;
  logic [DW-1:0]      f_data;
  logic [GAIN_W-1:0]  h_gain, n_gain;
  logic [DAC_W-1:0]   h_dac, n_dac;
  logic [CLAMP_W-1:0] h_clamp, n_clamp;
  logic [CTRL_W-1:0]  h_ctrl, n_ctrl;
  logic               h_ext, n_ext;
  logic               fs_q, fs_qq, load;

  assign f_addr = frm[FRAME_W-1 -: ADDR_W];
  assign f_data = frm[DW-1:0];

  always_comb begin
    n_gain  = h_gain;
    n_dac   = h_dac;
    n_clamp = h_clamp;
    n_ctrl  = h_ctrl;
    n_ext   = h_ext;
    if (frm_vld) begin
      case (f_addr)
        A_GAIN:  n_gain  = f_data[GAIN_W-1:0];
        A_DAC:   n_dac   = f_data[DAC_W-1:0];
        A_CLAMP: n_clamp = f_data[CLAMP_W-1:0];
        A_CTRL:  n_ctrl  = f_data[CTRL_W-1:0];
        A_EXT:   n_ext   = f_data[EXT_BIT];
        default: ;
      endcase
    end
  end

  assign load = ctrl_act[EDGE_BIT] ? (fs_qq && !fs_q) : (!fs_qq && fs_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_gain <= '0; h_dac <= '0; h_clamp <= '0; h_ctrl <= CTRL_RST; h_ext <= 1'b0;
      gain_act <= '0; dac_act <= '0; clamp_act <= '0; ctrl_act <= CTRL_RST; ext_act <= 1'b0;
      fs_q <= 1'b0; fs_qq <= 1'b0;
    end else begin
      fs_q  <= fs;
      fs_qq <= fs_q;
      h_gain <= n_gain; h_dac <= n_dac; h_clamp <= n_clamp; h_ctrl <= n_ctrl; h_ext <= n_ext;
      if (load) begin
        gain_act  <= n_gain;
        dac_act   <= n_dac;
        clamp_act <= n_clamp;
        ctrl_act  <= n_ctrl;
        ext_act   <= n_ext;
      end
    end
  end

  // R3
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({gain_act, dac_act, clamp_act, ctrl_act, ext_act}));

  // R6
  test_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_vld && f_addr > A_EXT) |=> $stable({h_gain, h_dac, h_clamp, h_ctrl, h_ext}));
endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port
  import ser_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_data,
  input  logic               ser_clk,
  input  logic               ser_en,
  input  logic               frame_sync,
  output logic [GAIN_W-1:0]  gain_code,
  output logic [DAC_W-1:0]   dac_code,
  output logic [CLAMP_W-1:0] clamp_code,
  output logic [CTRL_W-1:0]  ctrl_word,
  output logic               gain_ext
);
  logic [3:0] raw, synced;
  logic               frm_vld;
  logic [FRAME_W-1:0] frm;

  assign raw = {frame_sync, ser_en, ser_clk, ser_data};

  ser_cfg_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  ser_cfg_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .sd(synced[0]), .sck(synced[1]), .sen(synced[2]),
    .frm_vld(frm_vld), .frm(frm)
  );

  ser_cfg_bank #(.FRAME_W(FRAME_W)) u_bank (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm(frm), .fs(synced[3]),
    .gain_act(gain_code), .dac_act(dac_code), .clamp_act(clamp_code),
    .ctrl_act(ctrl_word), .ext_act(gain_ext)
  );
endmodule

// File: tb/ser_cfg_port_bench.sv
`timescale 1ns/1ps
module ser_cfg_port_bench;
  logic clk = 0, rst = 1;
  logic ser_data = 0, ser_clk = 1, ser_en = 0, fs_drv = 0, tie = 0;
  logic frame_sync;
  logic [7:0] gain_code, dac_code;
  logic [6:0] clamp_code;
  logic [9:0] ctrl_word;
  logic gain_ext;
  int compared = 0, mismatched = 0;

  typedef struct {
    logic [7:0] g; logic [7:0] d; logic [6:0] c; logic [9:0] w; logic x; string tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  assign frame_sync = tie ? ser_en : fs_drv;

  ser_cfg_port u_ser_cfg_port (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk), .ser_en(ser_en),
    .frame_sync(frame_sync), .gain_code(gain_code), .dac_code(dac_code),
    .clamp_code(clamp_code), .ctrl_word(ctrl_word), .gain_ext(gain_ext)
  );

  task automatic cmp(string tag, string f, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, f, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (q.size() != 0);
      repeat (12) @(negedge clk);
      e = q.pop_front();
      cmp(e.tag, "gain", gain_code, e.g);
      cmp(e.tag, "dac", dac_code, e.d);
      cmp(e.tag, "clamp", clamp_code, e.c);
      cmp(e.tag, "ctrl", ctrl_word, e.w);
      cmp(e.tag, "ext", gain_ext, e.x);
    end
  end

  task automatic expect_now(logic [7:0] g, logic [7:0] d, logic [6:0] c,
                            logic [9:0] w, logic x, string tag);
    exp_t e;
    e.g = g; e.d = d; e.c = c; e.w = w; e.x = x; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic send(logic [3:0] a, logic [11:0] dat, int nclk);
    logic [15:0] fr;
    fr = {a, dat};
    @(negedge clk);
    ser_en = 1;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      ser_data = (i < 16) ? fr[15-i] : 1'b0;
      repeat (8) @(negedge clk);
      ser_clk = 0;
      repeat (8) @(negedge clk);
      ser_clk = 1;
    end
    repeat (8) @(negedge clk);
    ser_en = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic fs_rise(); fs_drv = 1; repeat (10) @(negedge clk); endtask
  task automatic fs_fall(); fs_drv = 0; repeat (10) @(negedge clk); endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    expect_now(8'h00, 8'h00, 7'h00, 10'h204, 0, "R1 reset");

    send(4'd0, 12'h05A, 16);
    expect_now(8'h00, 8'h00, 7'h00, 10'h204, 0, "R3 no load yet");
    fs_rise(); fs_fall();
    expect_now(8'h5A, 8'h00, 7'h00, 10'h204, 0, "R2 gain frame");

    send(4'd1, 12'hFC3, 16);
    send(4'd2, 12'hFFF, 16);
    expect_now(8'h5A, 8'h00, 7'h00, 10'h204, 0, "R3 two pending");
    fs_rise(); fs_fall();
    expect_now(8'h5A, 8'hC3, 7'h7F, 10'h204, 0, "R4 dac clamp");

    send(4'd0, 12'h011, 15);
    send(4'd0, 12'h022, 17);
    fs_rise(); fs_fall();
    expect_now(8'h5A, 8'hC3, 7'h7F, 10'h204, 0, "R5 bad length");

    send(4'd5, 12'hFFF, 16);
    send(4'd15, 12'hFFF, 16);
    fs_rise(); fs_fall();
    expect_now(8'h5A, 8'hC3, 7'h7F, 10'h204, 0, "R6 test addr");

    send(4'd4, 12'h080, 16);
    send(4'd0, 12'hF12, 16);
    fs_rise(); fs_fall();
    expect_now(8'h12, 8'hC3, 7'h7F, 10'h204, 1, "R4 ext and gain");

    send(4'd3, 12'hFFF, 16);
    fs_rise();
    expect_now(8'h12, 8'hC3, 7'h7F, 10'h3FF, 1, "R7 rise loads ctrl");
    fs_fall();
    send(4'd0, 12'h033, 16);
    fs_rise();
    expect_now(8'h12, 8'hC3, 7'h7F, 10'h3FF, 1, "R7 rise ignored");
    fs_fall();
    expect_now(8'h33, 8'hC3, 7'h7F, 10'h3FF, 1, "R7 fall loads");

    tie = 1;
    send(4'd1, 12'h044, 16);
    expect_now(8'h33, 8'h44, 7'h7F, 10'h3FF, 1, "R8 tied strobe");
    tie = 0;

    send(4'd3, 12'h204, 16);
    fs_rise(); fs_fall();
    expect_now(8'h33, 8'h44, 7'h7F, 10'h204, 1, "R7 back to rise");
    send(4'd2, 12'h001, 16);
    fs_rise();
    expect_now(8'h33, 8'h44, 7'h01, 10'h204, 1, "R7 rise mode again");
    fs_fall();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule